// File: doc/BRIEF.md
# Power-Management Acknowledge Sequencer

This block drives the acknowledge phase of a link-layer power-management handshake. A request moves it from its resting wait state into the acknowledge state. In that state it drives the acknowledge output high on every cycle. It counts advance pulses from the physical layer and returns to the wait state after seven of them have arrived.

If the PHY-ready input falls while the block is acknowledging, the block leaves at once, whatever the count. The count is cleared on every exit, so a later acknowledge phase always starts counting from zero. Exits act as a strong abort: the acknowledge output is already low in the cycle that causes the exit, and the state indication drops on the next clock edge.

The reset is asynchronous when asserted and is released through a two-stage synchronizer. The number of advance pulses is a parameter.

Top module: `pm_ack_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `in_ack` is 0 and `ack` is 0 until a request arrives. Asserting `rst_n` low while in the acknowledge state forces `in_ack` to 0 without waiting for a clock edge.
- R2: In the wait state (`in_ack`=0), `enter_req`=1 at a clock edge sets `in_ack`=1 after that edge, with the advance count at zero.
- R3: In the acknowledge state, `ack` is 1 in every cycle where `phy_rdy`=1, unless that cycle carries the seventh advance pulse.
- R4: In the acknowledge state, the cycle with `phy_rdy`=1 and the seventh counted `adv` pulse has `ack`=0. `in_ack` is 0 after the following edge.
- R5: Only cycles in acknowledge state with `adv`=1 and `phy_rdy`=1 advance the count. Cycles with `adv`=0 leave it unchanged, so pulses with gaps between them still total seven.
- R6: In the acknowledge state, `phy_rdy`=0 makes `ack` 0 in that same cycle and `in_ack` 0 after the next edge, whatever the count or `adv`.
- R7: Every exit clears the count, including a `phy_rdy` drop in the cycle carrying the seventh pulse. The next acknowledge phase then needs a full seven pulses.
- R8: In the wait state `ack` is 0, and `adv` pulses are not counted toward a later phase.
- R9: `enter_req` while already in the acknowledge state has no effect: it neither restarts nor clears the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enter_req | input | 1 | Request to enter the acknowledge phase |
| adv | input | 1 | Advance pulse from the physical layer |
| phy_rdy | input | 1 | Physical layer ready; low aborts the acknowledge phase |
| ack | output | 1 | Acknowledge, high throughout the acknowledge phase |
| in_ack | output | 1 | State indication: 1 = acknowledge state, 0 = wait state |

## Verification
The bench targets the following cases:

- **Ready drop on the seventh pulse.** The bench drops `phy_rdy` in the same cycle as the seventh pulse, then re-enters. A design that clears its count only on normal completion would carry a stale count forward and exit early in the next phase.
- **Pulses in the wait state and requests during acknowledge.** The bench sends `adv` pulses while waiting and a repeat `enter_req` while acknowledging. These expose a counter that runs in the wrong state or restarts on a second request, since either would shift the exit cycle.
- **Pulses with gaps.** Pulses arrive with idle cycles between them. A design that counts cycles instead of pulses would exit too early.
- **Entry with the physical layer not ready.** The bench enters while `phy_rdy` is already low. This checks that the abort is taken on the first acknowledge cycle.
- **Ack on the exit cycle.** In every case above, the bench compares `ack` on the exit cycle itself. A weak-abort design would still drive it high there.

// File: rtl/pm_ack_pkg.sv
`timescale 1ns/1ps
package pm_ack_pkg;
  typedef enum logic {
    PM_WAIT = 1'b0,
    PM_ACK  = 1'b1
  } pm_state_e;
endpackage

// File: rtl/pm_rst_sync.sv
`timescale 1ns/1ps
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_adv_counter.sv
`timescale 1ns/1ps
module pm_adv_counter #(
  parameter int MODULUS = 7,
  localparam int W = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // clear has priority over increment
  always_comb begin
    cnt_en = clr | inc;
    if (clr)               cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                   cnt_d = cnt_q + W'(1);
  end

  assign wrap = inc & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pm_ack_fsm.sv
`timescale 1ns/1ps
module pm_ack_fsm
  import pm_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic adv,
  input  logic phy_rdy,
  input  logic wrap,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic ack,
  output logic in_ack
);
  pm_state_e state_q, state_d;
  logic      acking, abort_now, done_now;

  always_comb begin
    acking    = (state_q == PM_ACK);
    abort_now = acking & ~phy_rdy;
    cnt_inc   = acking & phy_rdy & adv;
    done_now  = acking & phy_rdy & wrap;
    // one clear path covers entry and both kinds of exit
    cnt_clr   = abort_now | done_now | (~acking & enter_req);
    // strong abort: no acknowledge in the exit cycle
    ack       = acking & ~abort_now & ~done_now;
    state_d   = state_q;
    unique case (state_q)
      PM_WAIT: if (enter_req)             state_d = PM_ACK;
      PM_ACK:  if (abort_now || done_now) state_d = PM_WAIT;
      default:                            state_d = PM_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_WAIT;
    else        state_q <= state_d;
  end

  assign in_ack = acking;
endmodule

// File: rtl/pm_ack_seq.sv
`timescale 1ns/1ps
module pm_ack_seq #(
  parameter int ADV_COUNT  = 7,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic adv,
  input  logic phy_rdy,
  output logic ack,
  output logic in_ack
);
  localparam int CNT_W = $clog2(ADV_COUNT);

  logic             rst_sync_n;
  logic             cnt_clr, cnt_inc, wrap;
  logic [CNT_W-1:0] cnt_q;

  pm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  pm_adv_counter #(.MODULUS(ADV_COUNT)) u_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt_q(cnt_q),
    .wrap (wrap)
  );

  pm_ack_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enter_req(enter_req),
    .adv      (adv),
    .phy_rdy  (phy_rdy),
    .wrap     (wrap),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .ack      (ack),
    .in_ack   (in_ack)
  );
endmodule

// File: rtl/pm_ack_seq_chk.sv
`timescale 1ns/1ps
module pm_ack_seq_chk #(
  parameter int MODULUS = 7,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enter_req,
  input logic             adv,
  input logic             phy_rdy,
  input logic             ack,
  input logic             in_ack,
  input logic [CNT_W-1:0] cnt
);
  AST_ENTER_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ack && enter_req |=> in_ack); // R2
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && phy_rdy && !adv |-> ack); // R3
  AST_LAST_PULSE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && phy_rdy && adv && cnt == CNT_W'(MODULUS-1) |-> !ack); // R4
  AST_LAST_PULSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && phy_rdy && adv && cnt == CNT_W'(MODULUS-1) |=> !in_ack); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MODULUS)); // R5
  AST_IDLE_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && phy_rdy && !adv |=> $stable(cnt)); // R5
  AST_DROP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !phy_rdy |-> !ack); // R6
  AST_DROP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !phy_rdy |=> !in_ack); // R6
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !phy_rdy |=> cnt == '0); // R7
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ack |-> !ack && cnt == '0); // R8
endmodule

bind pm_ack_seq pm_ack_seq_chk #(.MODULUS(ADV_COUNT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .enter_req(enter_req),
  .adv      (adv),
  .phy_rdy  (phy_rdy),
  .ack      (ack),
  .in_ack   (in_ack),
  .cnt      (cnt_q)
);

// File: tb/tb_pm_ack_seq.sv
`timescale 1ns/1ps
module tb_pm_ack_seq;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n, enter_req, adv, phy_rdy;
  logic ack, in_ack;
  int   checks = 0;
  int   errors = 0;
  bit   m_ack  = 1'b0;
  int   m_cnt  = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  pm_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .adv(adv),
    .phy_rdy(phy_rdy), .ack(ack), .in_ack(in_ack)
  );

  task automatic check(input string tag, input logic exp_ack, input logic exp_st);
    checks++;
    if (ack !== exp_ack || in_ack !== exp_st) begin
      errors++;
      $display("FAIL %s: ack=%b in_ack=%b expected ack=%b in_ack=%b at %0t",
               tag, ack, in_ack, exp_ack, exp_st, $time);
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic step(input logic r, input logic a, input logic p, input string tag);
    @(negedge clk);
    enter_req = r; adv = a; phy_rdy = p;
    #5;
    check(tag, m_ack && p && !(a && m_cnt == N-1), m_ack);
    @(posedge clk);
    if (!m_ack) begin
      if (r) begin m_ack = 1'b1; m_cnt = 0; end
    end else if (!p) begin
      m_ack = 1'b0; m_cnt = 0;
    end else if (a) begin
      if (m_cnt == N-1) begin m_ack = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enter_req = 1'b0; adv = 1'b0; phy_rdy = 1'b1;
    repeat (2) begin @(negedge clk); #5; check("R1 in reset", 1'b0, 1'b0); end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(0, 0, 1, "R1 after release");

    // R2 R3 R4: straight run of seven pulses
    step(1, 0, 1, "R2 enter");
    step(0, 0, 1, "R3 hold");
    for (int i = 0; i < N; i++) step(0, 1, 1, "R4 pulse run");
    step(0, 0, 1, "R4 back in wait");

    // R8: pulses in wait are not counted
    repeat (3) step(0, 1, 1, "R8 wait pulses");
    step(1, 1, 1, "R2 enter with pulse");
    // R5 R9: gapped pulses and repeat request
    for (int i = 0; i < N; i++) begin
      step(0, 0, 1, "R5 gap");
      step((i == 3), 1, 1, "R9 gapped pulse");
    end
    step(0, 0, 1, "R5 exited after seven");

    // R6 R7: drop mid-count, then full seven again
    step(1, 0, 1, "R2 enter");
    repeat (3) step(0, 1, 1, "R5 count");
    step(0, 1, 0, "R6 drop");
    step(0, 0, 1, "R6 in wait");
    step(1, 0, 1, "R2 reenter");
    for (int i = 0; i < N; i++) step(0, 1, 1, "R7 full count after drop");

    // R7: drop on the seventh pulse
    step(1, 0, 1, "R2 enter");
    repeat (N-1) step(0, 1, 1, "R5 count");
    step(0, 1, 0, "R7 drop on last pulse");
    step(1, 0, 1, "R2 reenter");
    for (int i = 0; i < N; i++) step(0, 1, 1, "R7 no stale count");

    // R6: entry while not ready
    step(1, 0, 0, "R2 enter not ready");
    step(0, 0, 0, "R6 first cycle abort");
    step(0, 0, 1, "R6 wait");

    // R1: asynchronous reset during acknowledge
    step(1, 0, 1, "R2 enter");
    step(0, 1, 1, "R3 hold");
    @(negedge clk); rst_n = 1'b0; enter_req = 1'b0; adv = 1'b0; #2;
    check("R1 async reset", 1'b0, 1'b0);
    m_ack = 1'b0; m_cnt = 0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(0, 0, 1, "R1 after second release");
    step(1, 0, 1, "R2 enter after reset");
    for (int i = 0; i < N; i++) step(0, 1, 1, "R7 full count after reset");
    step(0, 0, 1, "R8 wait");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule